// File: doc/BRIEF.md
# Data-Space Address Generator and Decoder

This block forms the effective address of every load or store in a small 8-bit microcontroller core and maps that address onto one flat 16-bit data space. The space holds four regions: the 32 working registers, the 64 standard I/O registers, the 160 extended I/O registers, and internal SRAM (512 bytes by default, set by a parameter). The working registers and the SRAM are held inside the block. The two I/O regions belong to peripherals outside the block, which return their read data on `io_rdata`.

An access starts with a one-cycle `start` strobe that carries an addressing mode, a pointer select, a direct address, a 6-bit displacement and, for stores, the write data. The three 16-bit pointers X, Y and Z are not separate registers. They are the register-file byte pairs 26/27, 28/29 and 30/31, each with the low byte at the even index. Pre-decrement and post-increment modes write the updated pointer back into those bytes. The first cycle computes the address. In the second cycle the address is valid and the read or write strobe is active. A done pulse then delivers the read data.

Top module: `dspace_agu`

## Requirements
- R1: Region decode, with exactly one select high during an in-range access: 0x0000–0x001F gives `sel_reg`, 0x0020–0x005F gives `sel_io`, 0x0060–0x00FF gives `sel_ext`, and 0x0100 up to 0x00FF+SRAM_BYTES gives `sel_sram`.
- R2: Mode 0 (direct) uses `direct_addr` as the effective address for any `ptr_sel`.
- R3: Mode 1 (indirect) uses the pointer picked by `ptr_sel` (0=X from bytes 26/27, 1=Y from 28/29, 2=Z from 30/31, low byte at the even index) as the address.
- R4: Mode 2 (displacement) uses Y or Z plus the unsigned 6-bit `disp` (0..63), wrapping modulo 2^16. The pointer is left unchanged.
- R5: Mode 3 (pre-decrement) subtracts one from the pointer modulo 2^16, uses the result as the address, and writes it back to the pointer bytes.
- R6: Mode 4 (post-increment) uses the pointer as the address and writes back the pointer plus one, modulo 2^16 (0xFFFF becomes 0x0000).
- R7: A `start` accepted at clock edge k gives `busy`, `eff_addr` and one strobe (`rd_stb` when `wr_en`=0, `wr_stb` when `wr_en`=1) in the cycle after k. `done` follows in the cycle after edge k+1. The two strobes are never high together.
- R8: An address above the top of SRAM raises `out_of_range` in the access cycle with no strobe and no select. The read returns 0x00 and a write changes nothing.
- R9: Displacement with X, any pointer mode with `ptr_sel`=3, and modes 5–7 are illegal. An illegal request pulses `illegal` in the cycle after the edge, makes no access, gives no `done` and leaves the pointers unchanged.
- R10: At `done`, `rdata` holds the register-file or SRAM byte, or `io_rdata` (sampled during the access cycle) for either I/O region. After a write, `rdata` is 0x00.
- R11: A `start` seen while `busy` is high is ignored.
- R12: A direct write to bytes 26–31 changes the pointer used by later indirect accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode (0 direct, 1 indirect, 2 displacement, 3 pre-decrement, 4 post-increment) |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| direct_addr | input | 16 | Address for direct mode |
| disp | input | 6 | Unsigned displacement |
| wr_en | input | 1 | 1 = store, 0 = load |
| wdata | input | 8 | Store data |
| io_rdata | input | 8 | Read data from the I/O and extended I/O peripherals |
| busy | output | 1 | Access cycle in progress |
| eff_addr | output | 16 | Effective address, valid while busy |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| sel_reg | output | 1 | Register-file region selected |
| sel_io | output | 1 | Standard I/O region selected |
| sel_ext | output | 1 | Extended I/O region selected |
| sel_sram | output | 1 | SRAM region selected |
| out_of_range | output | 1 | Address beyond the top of SRAM |
| illegal | output | 1 | Rejected request pulse |
| done | output | 1 | Access-complete pulse |
| rdata | output | 8 | Load data, valid with done |

## Verification
Inputs change on the falling edge, so the start is taken at the next rising edge. The bench checks the first-cycle results (`busy`, `eff_addr`, strobes, region selects, `out_of_range`, `illegal`) at the falling edge half a cycle after that rising edge. It checks `done` and `rdata` one full cycle later, at the next falling edge. A pointer write-back is never read out directly. It is confirmed through the effective address of a later access and through direct reads of bytes 26–31, both of which the bench predicts from its own byte-level model.

// File: rtl/dsag_pkg.sv
package dsag_pkg;
  localparam logic [2:0] AM_DIRECT  = 3'd0;
  localparam logic [2:0] AM_IND     = 3'd1;
  localparam logic [2:0] AM_DISP    = 3'd2;
  localparam logic [2:0] AM_PREDEC  = 3'd3;
  localparam logic [2:0] AM_POSTINC = 3'd4;

  localparam logic [1:0] PS_X = 2'd0;
  localparam logic [1:0] PS_Y = 2'd1;
  localparam logic [1:0] PS_Z = 2'd2;

  localparam logic [15:0] IO_BASE   = 16'h0020;
  localparam logic [15:0] EXT_BASE  = 16'h0060;
  localparam logic [15:0] SRAM_BASE = 16'h0100;

  typedef enum logic [1:0] {RG_REG, RG_IO, RG_EXT, RG_SRAM} region_e;
  typedef enum logic {PH_IDLE, PH_ACCESS} phase_e;

  function automatic logic [15:0] disp_add(input logic [15:0] base, input logic [5:0] d);
    return base + {10'd0, d};
  endfunction

  function automatic logic [15:0] ptr_step(input logic [15:0] p, input logic down);
    return down ? (p - 16'd1) : (p + 16'd1);
  endfunction

  function automatic logic [4:0] ptr_low_idx(input logic [1:0] sel);
    return 5'd26 + {2'b00, sel, 1'b0};
  endfunction
endpackage

// File: rtl/dsag_addr_calc.sv
module dsag_addr_calc
  import dsag_pkg::*;
(
  input  logic [2:0]  mode,
  input  logic [1:0]  ptr_sel,
  input  logic [15:0] direct_addr,
  input  logic [5:0]  disp,
  input  logic [15:0] x_ptr,
  input  logic [15:0] y_ptr,
  input  logic [15:0] z_ptr,
  output logic [15:0] eff,
  output logic [15:0] ptr_new,
  output logic        ptr_wb,
  output logic        bad_req
);
  logic [15:0] ptr;
  logic        sel_ok;

  always_comb begin
    case (ptr_sel)
      PS_X:    ptr = x_ptr;
      PS_Y:    ptr = y_ptr;
      PS_Z:    ptr = z_ptr;
      default: ptr = 16'd0;
    endcase
    sel_ok = (ptr_sel != 2'd3);
  end

  always_comb begin
    eff     = 16'd0;
    ptr_new = ptr;
    ptr_wb  = 1'b0;
    bad_req = 1'b0;
    case (mode)
      AM_DIRECT: eff = direct_addr;
      AM_IND: begin
        eff     = ptr;
        bad_req = !sel_ok;
      end
      AM_DISP: begin
        eff     = disp_add(ptr, disp);
        bad_req = (ptr_sel != PS_Y) && (ptr_sel != PS_Z);
      end
      AM_PREDEC: begin
        ptr_new = ptr_step(ptr, 1'b1);
        eff     = ptr_new;
        ptr_wb  = 1'b1;
        bad_req = !sel_ok;
      end
      AM_POSTINC: begin
        ptr_new = ptr_step(ptr, 1'b0);
        eff     = ptr;
        ptr_wb  = 1'b1;
        bad_req = !sel_ok;
      end
      default: bad_req = 1'b1;
    endcase
  end
endmodule

// File: rtl/dsag_region_dec.sv
module dsag_region_dec
  import dsag_pkg::*;
#(
  parameter int unsigned SRAM_BYTES = 512
) (
  input  logic [15:0] addr,
  output region_e     region,
  output logic        in_range
);
  localparam logic [16:0] TOP17 = 17'(256 + SRAM_BYTES - 1);

  always_comb begin
    in_range = ({1'b0, addr} <= TOP17);
    if (addr < IO_BASE)        region = RG_REG;
    else if (addr < EXT_BASE)  region = RG_IO;
    else if (addr < SRAM_BASE) region = RG_EXT;
    else                       region = RG_SRAM;
  end
endmodule

// File: rtl/dsag_regfile.sv
module dsag_regfile
  import dsag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_we,
  input  logic [1:0]  ptr_idx,
  input  logic [15:0] ptr_val,
  input  logic        dat_we,
  input  logic [4:0]  dat_idx,
  input  logic [7:0]  dat_val,
  input  logic [4:0]  rd_idx,
  output logic [7:0]  rd_val,
  output logic [15:0] x_ptr,
  output logic [15:0] y_ptr,
  output logic [15:0] z_ptr
);
  logic [7:0] rf [32];
  logic [4:0] lo_idx;
  logic [4:0] hi_idx;

  assign lo_idx = ptr_low_idx(ptr_idx);
  assign hi_idx = lo_idx + 5'd1;
  assign x_ptr  = {rf[27], rf[26]};
  assign y_ptr  = {rf[29], rf[28]};
  assign z_ptr  = {rf[31], rf[30]};
  assign rd_val = rf[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 8'h00;
    end else begin
      if (ptr_we) begin
        rf[lo_idx] <= ptr_val[7:0];
        rf[hi_idx] <= ptr_val[15:8];
      end
      if (dat_we) rf[dat_idx] <= dat_val;
    end
  end

  // R5 / R6: a pointer write-back is visible as the pointer in the next cycle
  assert_ptr_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (($past(ptr_idx) == PS_X) ? x_ptr :
                ($past(ptr_idx) == PS_Y) ? y_ptr : z_ptr) == $past(ptr_val));
endmodule

// File: rtl/dsag_sram.sv
module dsag_sram #(
  parameter int unsigned BYTES = 512,
  localparam int unsigned AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wval,
  output logic [7:0]    rval
);
  logic [7:0] mem [BYTES];

  assign rval = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wval;
  end
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
  import dsag_pkg::*;
#(
  parameter int unsigned SRAM_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  mode,
  input  logic [1:0]  ptr_sel,
  input  logic [15:0] direct_addr,
  input  logic [5:0]  disp,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  input  logic [7:0]  io_rdata,
  output logic        busy,
  output logic [15:0] eff_addr,
  output logic        rd_stb,
  output logic        wr_stb,
  output logic        sel_reg,
  output logic        sel_io,
  output logic        sel_ext,
  output logic        sel_sram,
  output logic        out_of_range,
  output logic        illegal,
  output logic        done,
  output logic [7:0]  rdata
);
  localparam int unsigned AW = $clog2(SRAM_BYTES);

  phase_e      phase;
  logic [15:0] addr_q;
  logic        wr_q;
  logic [7:0]  wdata_q;
  logic        done_q;
  logic        illegal_q;
  logic [7:0]  rdata_q;

  logic [15:0] x_ptr, y_ptr, z_ptr;
  logic [15:0] calc_eff, calc_ptr;
  logic        calc_wb, calc_bad;
  logic        accept, accept_ok, in_access;
  region_e     region;
  logic        in_range;
  logic [7:0]  rf_val, sram_val, read_mux;
  logic [AW-1:0] sram_idx;

  assign accept    = start && (phase == PH_IDLE);
  assign accept_ok = accept && !calc_bad;
  assign in_access = (phase == PH_ACCESS);

  dsag_addr_calc u_calc (
    .mode(mode), .ptr_sel(ptr_sel), .direct_addr(direct_addr), .disp(disp),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr),
    .eff(calc_eff), .ptr_new(calc_ptr), .ptr_wb(calc_wb), .bad_req(calc_bad)
  );

  dsag_region_dec #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
    .addr(addr_q), .region(region), .in_range(in_range)
  );

  assign rd_stb       = in_access && !wr_q && in_range;
  assign wr_stb       = in_access && wr_q && in_range;
  assign sel_reg      = in_access && in_range && (region == RG_REG);
  assign sel_io       = in_access && in_range && (region == RG_IO);
  assign sel_ext      = in_access && in_range && (region == RG_EXT);
  assign sel_sram     = in_access && in_range && (region == RG_SRAM);
  assign out_of_range = in_access && !in_range;
  assign sram_idx     = AW'(addr_q - SRAM_BASE);

  dsag_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .ptr_we(accept_ok && calc_wb), .ptr_idx(ptr_sel), .ptr_val(calc_ptr),
    .dat_we(wr_stb && sel_reg), .dat_idx(addr_q[4:0]), .dat_val(wdata_q),
    .rd_idx(addr_q[4:0]), .rd_val(rf_val),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr)
  );

  dsag_sram #(.BYTES(SRAM_BYTES)) u_sram (
    .clk(clk), .we(wr_stb && sel_sram), .idx(sram_idx),
    .wval(wdata_q), .rval(sram_val)
  );

  always_comb begin
    case (region)
      RG_REG:  read_mux = rf_val;
      RG_SRAM: read_mux = sram_val;
      default: read_mux = io_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      addr_q    <= 16'd0;
      wr_q      <= 1'b0;
      wdata_q   <= 8'd0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      rdata_q   <= 8'd0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      if (in_access) begin
        phase   <= PH_IDLE;
        done_q  <= 1'b1;
        rdata_q <= (rd_stb) ? read_mux : 8'h00;
      end else if (accept) begin
        if (calc_bad) begin
          illegal_q <= 1'b1;
        end else begin
          phase   <= PH_ACCESS;
          addr_q  <= calc_eff;
          wr_q    <= wr_en;
          wdata_q <= wdata;
        end
      end
    end
  end

  assign busy     = in_access;
  assign eff_addr = addr_q;
  assign done     = done_q;
  assign illegal  = illegal_q;
  assign rdata    = rdata_q;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  assert_done_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_access_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_region_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_reg, sel_io, sel_ext, sel_sram}));
  assert_strobe_has_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> $countones({sel_reg, sel_io, sel_ext, sel_sram}) == 1);
  assert_oor_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |=> (done && rdata == 8'h00));
  assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !done));
endmodule

// File: tb/sim_dspace_agu.sv
`timescale 1ns/1ps
module sim_dspace_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  ptr_sel = 2'd0;
  logic [15:0] direct_addr = 16'd0;
  logic [5:0]  disp = 6'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  io_rdata;
  logic        busy, rd_stb, wr_stb, sel_reg, sel_io, sel_ext, sel_sram;
  logic        out_of_range, illegal, done;
  logic [15:0] eff_addr;
  logic [7:0]  rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] rf_m [32];
  logic [7:0] sram_m [512];

  always #2 clk = ~clk;

  function automatic logic [7:0] io_fn(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  assign io_rdata = io_fn(eff_addr);

  dspace_agu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ptr_sel(ptr_sel),
    .direct_addr(direct_addr), .disp(disp), .wr_en(wr_en), .wdata(wdata),
    .io_rdata(io_rdata), .busy(busy), .eff_addr(eff_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .sel_reg(sel_reg), .sel_io(sel_io), .sel_ext(sel_ext),
    .sel_sram(sel_sram), .out_of_range(out_of_range), .illegal(illegal),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request; called and returns at a falling edge.
  task automatic acc(input logic [2:0] m, input logic [1:0] ps, input logic [15:0] da,
                     input logic [5:0] dp, input logic w, input logic [7:0] wd,
                     input string tag);
    logic [15:0] p, e, np;
    logic ill, wb, inr;
    logic [7:0] exp_rd;
    logic [3:0] exp_sel;
    int b;
    b = (ps < 2'd3) ? 26 + 2 * int'(ps) : 26;
    p = (ps < 2'd3) ? {rf_m[b+1], rf_m[b]} : 16'd0;
    ill = 1'b0; wb = 1'b0; np = p; e = 16'd0;
    case (m)
      3'd0: e = da;
      3'd1: begin e = p; ill = (ps == 2'd3); end
      3'd2: begin e = p + 16'(dp); ill = !(ps == 2'd1 || ps == 2'd2); end
      3'd3: begin np = p - 16'd1; e = np; wb = 1'b1; ill = (ps == 2'd3); end
      3'd4: begin e = p; np = p + 16'd1; wb = 1'b1; ill = (ps == 2'd3); end
      default: ill = 1'b1;
    endcase
    mode = m; ptr_sel = ps; direct_addr = da; disp = dp; wr_en = w; wdata = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ill) begin
      chk({tag, " R9 illegal"}, illegal, 1);
      chk({tag, " R9 no busy"}, busy, 0);
      chk({tag, " R9 no strobe"}, {rd_stb, wr_stb}, 0);
      @(negedge clk);
      chk({tag, " R9 no done"}, done, 0);
      return;
    end
    inr = (e <= 16'h02FF);
    exp_sel = !inr ? 4'b0000 : (e < 16'h0020) ? 4'b1000 : (e < 16'h0060) ? 4'b0100 :
              (e < 16'h0100) ? 4'b0010 : 4'b0001;
    chk({tag, " R7 busy"}, busy, 1);
    chk({tag, " R2/R3 eff_addr"}, eff_addr, e);
    chk({tag, " R1 selects"}, {sel_reg, sel_io, sel_ext, sel_sram}, exp_sel);
    chk({tag, " R7 strobes"}, {rd_stb, wr_stb}, inr ? (w ? 1 : 2) : 0);
    chk({tag, " R8 oor"}, out_of_range, !inr);
    if (wb) begin
      rf_m[b] = np[7:0];
      rf_m[b+1] = np[15:8];
    end
    if (!inr || w) exp_rd = 8'h00;
    else if (e < 16'h0020) exp_rd = rf_m[e[4:0]];
    else if (e < 16'h0100) exp_rd = io_fn(e);
    else exp_rd = sram_m[e - 16'h0100];
    if (w && inr) begin
      if (e < 16'h0020) rf_m[e[4:0]] = wd;
      else if (e >= 16'h0100) sram_m[e - 16'h0100] = wd;
    end
    @(negedge clk);
    chk({tag, " R7 done"}, done, 1);
    chk({tag, " R10 rdata"}, rdata, exp_rd);
    chk({tag, " R7 busy end"}, busy, 0);
  endtask

  task automatic set_ptr(input int sel, input logic [15:0] v);
    acc(3'd0, 2'd0, 16'(26 + 2 * sel), 6'd0, 1'b1, v[7:0], "R12 ptr lo");
    acc(3'd0, 2'd0, 16'(27 + 2 * sel), 6'd0, 1'b1, v[15:8], "R12 ptr hi");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf_m[i] = 8'h00;
    for (int i = 0; i < 512; i++) sram_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R7 reset strobes", {rd_stb, wr_stb}, 0);
    chk("R1 reset selects", {sel_reg, sel_io, sel_ext, sel_sram}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 512; i++)
      acc(3'd0, 2'd3, 16'(256 + i), 6'd0, 1'b1, 8'((i * 13 + 1) & 255), "R1 sram wr");
    for (int i = 0; i < 512; i++)
      acc(3'd0, 2'd0, 16'(256 + i), 6'd0, 1'b0, 8'd0, "R10 sram rd");
    for (int i = 0; i < 32; i++)
      acc(3'd0, 2'd1, 16'(i), 6'd0, 1'b1, 8'((i * 7 + 3) & 255), "R2 reg wr");
    for (int i = 0; i < 32; i++)
      acc(3'd0, 2'd0, 16'(i), 6'd0, 1'b0, 8'd0, "R2 reg rd");
    for (int i = 32; i < 256; i++)
      acc(3'd0, 2'd0, 16'(i), 6'd0, 1'b0, 8'd0, "R1 io rd");

    acc(3'd0, 2'd0, 16'h0300, 6'd0, 1'b1, 8'hA5, "R8 oor wr");
    acc(3'd0, 2'd0, 16'h0300, 6'd0, 1'b0, 8'd0, "R8 oor rd");
    acc(3'd0, 2'd0, 16'hFFFF, 6'd0, 1'b0, 8'd0, "R8 oor top");
    acc(3'd0, 2'd0, 16'h02FF, 6'd0, 1'b0, 8'd0, "R8 last sram");

    set_ptr(0, 16'h0100);
    set_ptr(1, 16'h0200);
    set_ptr(2, 16'h001C);
    for (int s = 0; s < 3; s++) acc(3'd1, 2'(s), 16'd0, 6'd0, 1'b0, 8'd0, "R3 indirect");
    acc(3'd1, 2'd2, 16'd0, 6'd0, 1'b1, 8'h3C, "R3 indirect wr");
    for (int i = 0; i < 20; i++) acc(3'd4, 2'd0, 16'd0, 6'd0, 1'b0, 8'd0, "R6 postinc");
    for (int i = 0; i < 10; i++) acc(3'd3, 2'd1, 16'd0, 6'd0, 1'b1, 8'(i), "R5 predec");
    for (int d = 0; d < 64; d++) acc(3'd2, 2'd1, 16'd0, 6'(d), 1'b0, 8'd0, "R4 disp Y");
    set_ptr(2, 16'hFFF0);
    for (int d = 0; d < 64; d++) acc(3'd2, 2'd2, 16'd0, 6'(d), 1'b0, 8'd0, "R4 disp Z wrap");

    set_ptr(0, 16'h0000);
    acc(3'd3, 2'd0, 16'd0, 6'd0, 1'b0, 8'd0, "R5 predec wrap");
    acc(3'd4, 2'd0, 16'd0, 6'd0, 1'b0, 8'd0, "R6 postinc at ffff");
    acc(3'd1, 2'd0, 16'd0, 6'd0, 1'b0, 8'd0, "R6 wrapped to 0");

    acc(3'd2, 2'd0, 16'd0, 6'd5, 1'b1, 8'h11, "R9 disp X");
    acc(3'd4, 2'd3, 16'd0, 6'd0, 1'b0, 8'd0, "R9 ptr 3");
    for (int m = 5; m < 8; m++) acc(3'(m), 2'd1, 16'd0, 6'd0, 1'b0, 8'd0, "R9 bad mode");
    for (int i = 26; i < 32; i++) acc(3'd0, 2'd0, 16'(i), 6'd0, 1'b0, 8'd0, "R9 ptr kept");

    // R11: second start while busy, a write, must be ignored
    mode = 3'd0; direct_addr = 16'h0150; wr_en = 1'b0; start = 1'b1;
    @(negedge clk);
    chk("R11 busy", busy, 1);
    wr_en = 1'b1; wdata = 8'hEE;
    @(negedge clk);
    start = 1'b0;
    chk("R11 first done", done, 1);
    chk("R11 first rdata", rdata, sram_m[16'h0050]);
    chk("R11 no second access", busy, 0);
    @(negedge clk);
    acc(3'd0, 2'd0, 16'h0150, 6'd0, 1'b0, 8'd0, "R11 unchanged");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule